// File: doc/BRIEF.md
# Integer ALU with Overflow and Compare

This block is the integer execute unit of a small RISC core. Each cycle it takes two 32-bit operands, a 5-bit shift distance and a 3-bit operation code. It returns a 32-bit result, an overflow flag and an operand-equality flag. The results sit in an output register, so they appear one clock after the inputs that produce them.

A single adder/subtractor serves both the overflow-checking and the wrapping add and subtract. The only difference between the two forms is whether the overflow flag may be raised. Signed and unsigned less-than are produced side by side, and either one drives bit 0 of the result. Branch logic uses the equality flag for branch-if-equal and branch-if-not-equal, whatever operation is selected.

Top module: `int_alu`

## Requirements
- R1: While `rst` is high at a rising clock edge, `result`, `ovf` and `equal` are all cleared to 0 at that edge.
- R2: Op code 0 (checked add) yields A+B modulo 2^32, and op code 1 (checked subtract) yields A-B modulo 2^32.
- R3: For op codes 0 and 1, `ovf` is 1 exactly when the true two's-complement result does not fit in 32 bits.
- R4: Op codes 2 (wrapping add) and 3 (wrapping subtract) give the same result as op codes 0 and 1, and `ovf` is 0.
- R5: Op code 4 (signed less-than) gives 1 in bit 0 when A < B as signed integers and 0 otherwise, with bits 31:1 zero.
- R6: Op code 5 (unsigned less-than) compares A and B as unsigned magnitudes and places the answer in bit 0, with bits 31:1 zero. For A=0xFFFFFFFA and B=0x0000FFFA, op 4 gives 1 and op 5 gives 0.
- R7: Op code 6 shifts A left by `shamt` and fills with zeros (0x00000002 shifted by 2 gives 0x00000008).
- R8: Op code 7 shifts A right by `shamt` and fills with zeros from the top.
- R9: `equal` is 1 exactly when A equals B, for every op code.
- R10: `ovf` is 0 for every op code other than 0 and 1.
- R11: All outputs reflect the inputs sampled at the previous rising edge, so latency is one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_sel | input | 3 | Operation code (0..7, see requirements) |
| opnd_a | input | 32 | Operand A (also the shifted value) |
| opnd_b | input | 32 | Operand B |
| shamt | input | 5 | Shift distance |
| result | output | 32 | Registered result |
| ovf | output | 1 | Registered signed overflow flag |
| equal | output | 1 | Registered operand-equality flag |

## Verification
Every cycle, assertions check four properties. The overflow flag may only follow a checked add or subtract. A less-than result never sets a bit above bit 0. The equality flag tracks the operands of the previous cycle. The shifter's vacated bit positions hold zeros. Whether each sum, difference, comparison and overflow value is numerically correct can only be shown by the bench scenarios. These include the signed boundary values, the mixed-sign compare case and the shift extremes, all checked against an independent model.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;
  localparam int OP_W = 3;
  typedef enum logic [OP_W-1:0] {
    OP_ADD_CHK = 3'd0,
    OP_SUB_CHK = 3'd1,
    OP_ADD_WRP = 3'd2,
    OP_SUB_WRP = 3'd3,
    OP_LT_SGN  = 3'd4,
    OP_LT_UNS  = 3'd5,
    OP_SHL     = 3'd6,
    OP_SHR     = 3'd7
  } alu_op_e;
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  input  logic         chk,
  output logic [W-1:0] sum,
  output logic         ovf
);
  logic [W-1:0] b_eff;
  logic         c_out;

  always_comb begin
    b_eff        = sub ? ~b : b;
    {c_out, sum} = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, sub};
    // same-sign inputs whose sum flips sign
    ovf = chk & (a[W-1] == b_eff[W-1]) & (sum[W-1] != a[W-1]);
  end
endmodule

// File: rtl/alu_cmp.sv
module alu_cmp #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         lt_s,
  output logic         lt_u,
  output logic         eq
);
  logic [W-1:0] diff;
  logic         borrow;

  always_comb begin
    {borrow, diff} = {1'b0, a} - {1'b0, b};
    lt_u = borrow;
    // differing signs: the negative one is smaller; else magnitude decides
    lt_s = (a[W-1] ^ b[W-1]) ? a[W-1] : borrow;
    eq   = (diff == '0);
  end
endmodule

// File: rtl/alu_shift.sv
module alu_shift #(
  parameter int W   = 32,
  parameter int SHW = $clog2(W)
) (
  input  logic [W-1:0]   din,
  input  logic [SHW-1:0] amt,
  output logic [W-1:0]   shl,
  output logic [W-1:0]   shr
);
  logic [W-1:0] lstage [SHW+1];
  logic [W-1:0] rstage [SHW+1];

  assign lstage[0] = din;
  assign rstage[0] = din;

  for (genvar s = 0; s < SHW; s++) begin : g_stage
    localparam int D = 1 << s;
    assign lstage[s+1] = amt[s] ? {lstage[s][W-1-D:0], {D{1'b0}}} : lstage[s];
    assign rstage[s+1] = amt[s] ? {{D{1'b0}}, rstage[s][W-1:D]}   : rstage[s];
  end

  assign shl = lstage[SHW];
  assign shr = rstage[SHW];

  logic [W-1:0] low_mask;
  always_comb begin
    low_mask = (W'(1) << amt) - W'(1);
    // R7
    shl_zero_fill_chk: assert ((shl & low_mask) == '0);
    // R8
    shr_zero_fill_chk: assert ((shr & ~(low_mask << (W - 32'(amt)))) == shr || amt == '0);
  end
endmodule

// File: rtl/int_alu.sv
module int_alu
  import int_alu_pkg::*;
#(
  parameter int W   = 32,
  parameter int SHW = $clog2(W)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [OP_W-1:0] op_sel,
  input  logic [W-1:0]   opnd_a,
  input  logic [W-1:0]   opnd_b,
  input  logic [SHW-1:0] shamt,
  output logic [W-1:0]   result,
  output logic           ovf,
  output logic           equal
);
  alu_op_e      op;
  logic         is_sub, is_chk;
  logic [W-1:0] sum, shl_v, shr_v;
  logic         ovf_c, lt_s, lt_u, eq_c;
  logic [W-1:0] res_c;

  assign op     = alu_op_e'(op_sel);
  assign is_sub = (op == OP_SUB_CHK) || (op == OP_SUB_WRP);
  assign is_chk = (op == OP_ADD_CHK) || (op == OP_SUB_CHK);

  alu_addsub #(.W(W)) u_addsub (
    .a(opnd_a), .b(opnd_b), .sub(is_sub), .chk(is_chk), .sum(sum), .ovf(ovf_c)
  );

  alu_cmp #(.W(W)) u_cmp (
    .a(opnd_a), .b(opnd_b), .lt_s(lt_s), .lt_u(lt_u), .eq(eq_c)
  );

  alu_shift #(.W(W), .SHW(SHW)) u_shift (
    .din(opnd_a), .amt(shamt), .shl(shl_v), .shr(shr_v)
  );

  always_comb begin
    unique case (op)
      OP_ADD_CHK, OP_SUB_CHK,
      OP_ADD_WRP, OP_SUB_WRP: res_c = sum;
      OP_LT_SGN:              res_c = {{(W-1){1'b0}}, lt_s};
      OP_LT_UNS:              res_c = {{(W-1){1'b0}}, lt_u};
      OP_SHL:                 res_c = shl_v;
      OP_SHR:                 res_c = shr_v;
      default:                res_c = '0;
    endcase
  end

  logic live_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      result <= '0;
      ovf    <= 1'b0;
      equal  <= 1'b0;
      live_q <= 1'b0;
    end else begin
      result <= res_c;
      ovf    <= ovf_c;
      equal  <= eq_c;
      live_q <= 1'b1;
    end
  end

  // R10
  ovf_only_chk_ops: assert property (@(posedge clk) disable iff (rst || !live_q)
    ovf |-> ($past(op_sel) == OP_ADD_CHK || $past(op_sel) == OP_SUB_CHK));

  // R4
  wrap_no_ovf_chk: assert property (@(posedge clk) disable iff (rst || !live_q)
    ($past(op_sel) == OP_ADD_WRP || $past(op_sel) == OP_SUB_WRP) |-> !ovf);

  // R5
  lt_upper_zero_chk: assert property (@(posedge clk) disable iff (rst || !live_q)
    ($past(op_sel) == OP_LT_SGN || $past(op_sel) == OP_LT_UNS) |-> (result[W-1:1] == '0));

  // R9
  equal_track_chk: assert property (@(posedge clk) disable iff (rst || !live_q)
    equal == ($past(opnd_a) == $past(opnd_b)));
endmodule

// File: tb/sim_int_alu.sv
`timescale 1ns/1ps
module sim_int_alu;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  op_sel = '0;
  logic [31:0] opnd_a = '0, opnd_b = '0;
  logic [4:0]  shamt = '0;
  logic [31:0] result;
  logic        ovf, equal;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  int_alu u0 (
    .clk(clk), .rst(rst), .op_sel(op_sel), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .shamt(shamt), .result(result), .ovf(ovf), .equal(equal)
  );

  function automatic logic [31:0] exp_res(input logic [2:0] o, input logic [31:0] a, b,
                                          input logic [4:0] s);
    case (o)
      3'd0, 3'd2: return a + b;
      3'd1, 3'd3: return a - b;
      3'd4:       return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
      3'd5:       return (a < b) ? 32'd1 : 32'd0;
      3'd6:       return a << s;
      default:    return a >> s;
    endcase
  endfunction

  function automatic logic exp_ovf(input logic [2:0] o, input logic [31:0] a, b);
    longint sa = longint'($signed(a));
    longint sb = longint'($signed(b));
    longint r;
    if (o == 3'd0)      r = sa + sb;
    else if (o == 3'd1) r = sa - sb;
    else return 1'b0;
    return (r > 64'sd2147483647) || (r < -64'sd2147483648);
  endfunction

  function automatic string op_tag(input logic [2:0] o);
    case (o)
      3'd0, 3'd1: return "R2";
      3'd2, 3'd3: return "R4";
      3'd4:       return "R5";
      3'd5:       return "R6";
      3'd6:       return "R7";
      default:    return "R8";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive at negedge, outputs valid after the next posedge (R11)
  task automatic run(input logic [2:0] o, input logic [31:0] a, b, input logic [4:0] s);
    op_sel = o; opnd_a = a; opnd_b = b; shamt = s;
    @(posedge clk); @(negedge clk);
    chk(op_tag(o), result, exp_res(o, a, b, s));
    chk((o <= 3'd1) ? "R3" : "R10", {31'd0, ovf}, {31'd0, exp_ovf(o, a, b)});
    chk("R9", {31'd0, equal}, {31'd0, a == b});
  endtask

  initial begin
    logic [31:0] tmp;
    void'($urandom(32'd1234));
    op_sel = 3'd0; opnd_a = 32'hFFFF_FFFF; opnd_b = 32'hFFFF_FFFF;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", result, 32'd0);
    chk("R1", {31'd0, ovf}, 32'd0);
    chk("R1", {31'd0, equal}, 32'd0);
    rst = 1'b0;

    // R11: output holds the previous cycle's value until the edge
    op_sel = 3'd2; opnd_a = 32'd5; opnd_b = 32'd6;
    @(posedge clk); @(negedge clk);
    op_sel = 3'd2; opnd_a = 32'd100; opnd_b = 32'd1;
    #1 chk("R11", result, 32'd11);
    @(posedge clk); @(negedge clk);
    chk("R11", result, 32'd101);

    // R3 boundaries
    run(3'd0, 32'h7FFF_FFFF, 32'd1, 0);
    run(3'd0, 32'h8000_0000, 32'h8000_0000, 0);
    run(3'd0, 32'h7FFF_FFFF, 32'h8000_0000, 0);
    run(3'd1, 32'h8000_0000, 32'd1, 0);
    run(3'd1, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 0);
    run(3'd1, 32'd0, 32'h8000_0000, 0);
    run(3'd1, 32'hFFFF_FFFF, 32'h8000_0000, 0);
    // R4 same sums, no flag
    run(3'd2, 32'h7FFF_FFFF, 32'd1, 0);
    run(3'd3, 32'h8000_0000, 32'd1, 0);
    // R5 / R6 mixed-sign case
    run(3'd4, 32'hFFFF_FFFA, 32'h0000_FFFA, 0);
    run(3'd5, 32'hFFFF_FFFA, 32'h0000_FFFA, 0);
    run(3'd4, 32'd7, 32'd7, 0);
    run(3'd5, 32'd3, 32'd9, 0);
    run(3'd4, 32'h8000_0000, 32'h7FFF_FFFF, 0);
    // R7 / R8
    run(3'd6, 32'h0000_0002, 32'd0, 5'd2);
    run(3'd6, 32'hFFFF_FFFF, 32'd0, 5'd31);
    run(3'd7, 32'h8000_0000, 32'd0, 5'd31);
    run(3'd7, 32'hFFFF_FFFF, 32'd0, 5'd0);
    // R9 equality under a shift op
    run(3'd6, 32'h1234_5678, 32'h1234_5678, 5'd4);

    for (int i = 0; i < 600; i++) begin
      tmp = $urandom;
      run(3'($urandom % 8), $urandom, (i % 5 == 0) ? tmp : $urandom, 5'($urandom));
    end

    // R1 again mid-run
    op_sel = 3'd0; opnd_a = 32'h7FFF_FFFF; opnd_b = 32'd1; rst = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R1", result, 32'd0);
    chk("R1", {31'd0, ovf}, 32'd0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(4 * 100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule